// File: doc/BRIEF.md
# Dual-Channel Conversion Result Formatter and Bus Multiplexer

This block sits behind a pair of converter channels, I and Q. On each falling clock edge it may take one 10-bit unsigned result for each channel, marked by a valid strobe. The results pass through a short pipeline. On a rising edge they are presented on the output buses. A format control chooses one of two output codings. In straight binary the code passes through unchanged. In two's complement the most significant bit is inverted.

A bus-select control chooses between two modes. In parallel mode each channel has its own bus. In multiplexed mode both channels share the I bus. The I word occupies the high half of the clock and the Q word the low half that follows, so Q reaches the bus half a cycle after I. A flag output marks the phase in multiplexed mode and pulses high on each update in parallel mode. The format and mode settings are latched together with the data at the output update, so one word is never coded two ways.

Top module: `dual_code_mux`

## Requirements
- R1: With bus_sel high (parallel mode), i_bus carries the formatted I result and q_bus the formatted Q result during the whole clock period after an update. Bit 0 is the LSB and bit 9 the MSB.
- R2: With bus_sel low (multiplexed mode), every bit of q_bus is 0.
- R3: In multiplexed mode, after an update the I word is on i_bus with flag high during the high half of the clock. The Q word of the same sample is on i_bus with flag low during the following low half.
- R4: The flag is low in every low clock half. In parallel mode it is high in the high half that follows each update, giving one rising edge per updated word.
- R5: fmt_sel low outputs the code unchanged (straight binary). fmt_sel high outputs the code with bit 9 inverted (two's complement).
- R6: A pair captured at a falling edge (in_valid high) reaches the output at the rising edge 2.5 cycles later. In multiplexed mode its Q word appears at the falling edge 3 cycles after capture.
- R7: fmt_sel and bus_sel are sampled at the rising edge that updates the outputs, and they apply to the whole word and period that follow.
- R8: When no valid pair arrives at an update, both buses hold their values and the flag stays low. In multiplexed mode i_bus keeps showing the last Q word.
- R9: A synchronous active-high reset clears i_bus, q_bus and flag to 0, discards pairs in flight, and selects multiplexed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; falling edge captures, rising edge updates |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a valid I/Q result pair |
| i_code | input | 10 | I-channel unsigned result |
| q_code | input | 10 | Q-channel unsigned result |
| fmt_sel | input | 1 | 0 straight binary, 1 two's complement |
| bus_sel | input | 1 | 1 parallel, 0 multiplexed |
| i_bus | output | 10 | I output bus (shared bus in multiplexed mode) |
| q_bus | output | 10 | Q output bus (0 in multiplexed mode) |
| flag | output | 1 | Channel phase / new-data marker |

## Verification
Back-to-back valid pairs, including the codes 0, 511, 512 and 1023, are used to separate the straight and inverted-MSB codings and to expose any bit-order error. Valid pairs mixed with idle gaps carrying garbage data show whether the buses hold and the flag stays quiet (R8), and they make the 2.5- and 3-cycle latencies visible. Toggling fmt_sel and bus_sel every cycle while data flows shows that each setting is tied to a single word. A reset in the middle of the stream checks that pairs in flight are dropped. Both clock halves are compared against the model on every cycle.

// File: rtl/dual_code_mux_pkg.sv
package dual_code_mux_pkg;
  typedef enum logic {
    CODE_BIN  = 1'b0,
    CODE_TWOS = 1'b1
  } code_fmt_e;
endpackage

// File: rtl/sample_pipe.sv
module sample_pipe #(
  parameter int W      = 10,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic         out_vld,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q
);
  localparam int LAST = STAGES - 1;

  logic         vld_r [STAGES];
  logic [W-1:0] i_r   [STAGES];
  logic [W-1:0] q_r   [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stg
    if (k == 0) begin : g_first
      always_ff @(negedge clk) begin
        if (rst) begin
          vld_r[k] <= 1'b0;
          i_r[k]   <= '0;
          q_r[k]   <= '0;
        end else begin
          vld_r[k] <= in_vld;
          i_r[k]   <= in_i;
          q_r[k]   <= in_q;
        end
      end
    end else begin : g_next
      always_ff @(negedge clk) begin
        if (rst) begin
          vld_r[k] <= 1'b0;
          i_r[k]   <= '0;
          q_r[k]   <= '0;
        end else begin
          vld_r[k] <= vld_r[k-1];
          i_r[k]   <= i_r[k-1];
          q_r[k]   <= q_r[k-1];
        end
      end
    end
  end

  assign out_vld = vld_r[LAST];
  assign out_i   = i_r[LAST];
  assign out_q   = q_r[LAST];
endmodule

// File: rtl/code_fmt.sv
module code_fmt
  import dual_code_mux_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] raw,
  input  code_fmt_e    mode,
  output logic [W-1:0] coded
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  assign coded = (mode == CODE_TWOS) ? (raw ^ MSB_MASK) : raw;
endmodule

// File: rtl/out_stage.sv
module out_stage
  import dual_code_mux_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_vld,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] s_q,
  input  logic         fmt_twos,
  input  logic         par_sel,
  output logic [W-1:0] o_i,
  output logic [W-1:0] o_q,
  output logic         o_vld,
  output logic         o_par,
  output logic [W-1:0] n_q
);
  code_fmt_e    mode;
  logic [W-1:0] f_i;
  logic [W-1:0] f_q;

  assign mode = fmt_twos ? CODE_TWOS : CODE_BIN;

  code_fmt #(.W(W)) u_fmt_i (.raw(s_i), .mode(mode), .coded(f_i));
  code_fmt #(.W(W)) u_fmt_q (.raw(s_q), .mode(mode), .coded(f_q));

  // Rising edge: the word update, with format and mode latched alongside it
  always_ff @(posedge clk) begin
    if (rst) begin
      o_i   <= '0;
      o_q   <= '0;
      o_vld <= 1'b0;
      o_par <= 1'b0;
    end else begin
      o_vld <= s_vld;
      o_par <= par_sel;
      if (s_vld) begin
        o_i <= f_i;
        o_q <= f_q;
      end
    end
  end

  // Falling edge: Q word for the low half of the multiplexed phase
  always_ff @(negedge clk) begin
    if (rst) n_q <= '0;
    else if (o_vld) n_q <= o_q;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !s_vld |=> ($stable(o_i) && $stable(o_q)));
endmodule

// File: rtl/dual_code_mux.sv
module dual_code_mux
  import dual_code_mux_pkg::*;
#(
  parameter int W      = 10,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] i_code,
  input  logic [W-1:0] q_code,
  input  logic         fmt_sel,
  input  logic         bus_sel,
  output logic [W-1:0] i_bus,
  output logic [W-1:0] q_bus,
  output logic         flag
);
  logic         s_vld;
  logic [W-1:0] s_i;
  logic [W-1:0] s_q;
  logic [W-1:0] o_i;
  logic [W-1:0] o_q;
  logic         o_vld;
  logic         o_par;
  logic [W-1:0] n_q;

  sample_pipe #(.W(W), .STAGES(STAGES)) u_pipe (
    .clk(clk), .rst(rst), .in_vld(in_valid), .in_i(i_code), .in_q(q_code),
    .out_vld(s_vld), .out_i(s_i), .out_q(s_q)
  );

  out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .s_vld(s_vld), .s_i(s_i), .s_q(s_q),
    .fmt_twos(fmt_sel), .par_sel(bus_sel),
    .o_i(o_i), .o_q(o_q), .o_vld(o_vld), .o_par(o_par), .n_q(n_q)
  );

  // Clock-phase selection of two registered words (double-rate output)
  always_comb begin
    if (o_par) begin
      i_bus = o_i;
      q_bus = o_q;
    end else begin
      i_bus = (clk && o_vld) ? o_i : n_q;
      q_bus = '0;
    end
    flag = clk & o_vld;
  end

  assert_par_buses_R1: assert property (@(negedge clk) disable iff (rst)
    o_par |-> (i_bus == o_i && q_bus == o_q));
  assert_q_zero_R2: assert property (@(negedge clk) disable iff (rst)
    !o_par |-> (q_bus == '0));
  assert_mux_i_high_R3: assert property (@(negedge clk) disable iff (rst)
    (!o_par && o_vld) |-> (i_bus == o_i && flag));
  assert_flag_low_half_R4: assert property (@(posedge clk) disable iff (rst)
    !flag);
endmodule

// File: tb/dual_code_mux_tb.sv
module dual_code_mux_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [9:0] i_code = '0;
  logic [9:0] q_code = '0;
  logic       fmt_sel = 1'b0;
  logic       bus_sel = 1'b0;
  logic [9:0] i_bus;
  logic [9:0] q_bus;
  logic       flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dual_code_mux u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .i_code(i_code), .q_code(q_code),
    .fmt_sel(fmt_sel), .bus_sel(bus_sel), .i_bus(i_bus), .q_bus(q_bus), .flag(flag)
  );

  // Behavioural reference: captured history plus expected visible words
  bit         cap_v[$];
  logic [9:0] cap_i[$];
  logic [9:0] cap_q[$];
  bit         mo_vld = 0;
  bit         mo_par = 0;
  bit         in_rst = 1;
  logic [9:0] mo_i = '0;
  logic [9:0] mo_q = '0;
  logic [9:0] mn_q = '0;

  function automatic logic [9:0] enc(input logic [9:0] x, input logic t);
    return t ? {~x[9], x[8:0]} : x;
  endfunction

  task automatic check_half(input bit hi);
    logic [9:0] ei, eq;
    logic       ef;
    string      tag;
    ef = hi && mo_vld;
    if (mo_par) begin ei = mo_i; eq = mo_q; end
    else begin ei = (hi && mo_vld) ? mo_i : mn_q; eq = '0; end
    if (in_rst) tag = "R9";
    else if (!mo_vld) tag = "R8 R4";
    else if (mo_par) tag = hi ? "R1 R4 R5 R6 R7" : "R1 R4";
    else tag = hi ? "R3 R5 R6 R7" : "R2 R3 R6";
    checks++;
    if (i_bus !== ei || q_bus !== eq || flag !== ef) begin
      fails++;
      $display("FAIL %s hi=%0d: i_bus=%h q_bus=%h flag=%b expected i_bus=%h q_bus=%h flag=%b",
               tag, hi, i_bus, q_bus, flag, ei, eq, ef);
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [9:0] a, input logic [9:0] b,
                      input bit f, input bit p);
    bit         wv;
    logic [9:0] wi, wq;
    rst = r; in_valid = v; i_code = a; q_code = b; fmt_sel = f; bus_sel = p;
    @(negedge clk);
    if (r) begin
      cap_v.delete(); cap_i.delete(); cap_q.delete();
      mn_q = '0;
    end else if (mo_vld) mn_q = mo_q;
    cap_v.push_back(r ? 1'b0 : v); cap_i.push_back(a); cap_q.push_back(b);
    #1 check_half(0);
    @(posedge clk);
    if (cap_v.size() >= 3) begin
      wv = cap_v[cap_v.size()-3]; wi = cap_i[cap_i.size()-3]; wq = cap_q[cap_q.size()-3];
    end else begin
      wv = 0; wi = '0; wq = '0;
    end
    in_rst = r;
    if (r) begin
      mo_vld = 0; mo_par = 0; mo_i = '0; mo_q = '0;
    end else begin
      mo_vld = wv; mo_par = p;
      if (wv) begin mo_i = enc(wi, f); mo_q = enc(wq, f); end
    end
    #1 check_half(1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R9: reset state
    repeat (3) step(1, 0, 10'h3FF, 10'h3FF, 0, 1);
    // R1 R5 R6: parallel, straight binary, edge codes
    step(0, 1, 10'd0,   10'd1023, 0, 1);
    step(0, 1, 10'd511, 10'd512,  0, 1);
    step(0, 1, 10'd1023, 10'd0,   0, 1);
    step(0, 1, 10'h155, 10'h2AA,  0, 1);
    // R8: idle gaps with garbage
    repeat (3) step(0, 0, 10'h3C3, 10'h03C, 0, 1);
    // R5: two's complement in parallel
    for (int k = 0; k < 6; k++)
      step(0, 1, 10'((k * 137) % 1024), 10'((1000 - k * 91) % 1024), 1, 1);
    // R7: format toggling each cycle
    for (int k = 0; k < 6; k++)
      step(0, 1, 10'(k * 170 + 3), 10'(900 - k * 60), k[0], 1);
    // R2 R3: multiplexed mode with gaps
    for (int k = 0; k < 10; k++)
      step(0, (k % 3) != 2, 10'(k * 97 + 1), 10'(1023 - k * 53), k > 4, 0);
    repeat (3) step(0, 0, 10'h2F0, 10'h00F, 0, 0);
    // R7: mode toggling each cycle
    for (int k = 0; k < 8; k++)
      step(0, 1, 10'(k * 61 + 512), 10'(k * 29), 0, k[0]);
    // R9: reset mid-stream discards pairs in flight
    step(0, 1, 10'h111, 10'h222, 0, 1);
    step(1, 1, 10'h333, 10'h044, 0, 1);
    step(0, 1, 10'h0AB, 10'h3CD, 1, 0);
    repeat (5) step(0, 0, 10'h000, 10'h000, 0, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule